// File: doc/BRIEF.md
# Enable-Latched Byte Static RAM

A 2048 x 8 static memory with one shared data path, modelled synchronously to a system clock. All three strobes are active low: chip enable, write enable and output enable. The clock samples each strobe and compares it with its value from the previous sample to find its edges. When chip enable falls, the address is taken into an internal holding register. The pins may then change freely until the next falling edge.

A read returns the byte at the held address. Output drive is controlled separately: the drive flag is raised only while chip enable is low, output enable is low and write enable is high. A write stays open while both chip enable and write enable are low. It ends at the first sample where either strobe is high again, and the byte on the write-data input at that sample is stored at the held address. The tri-state bus is represented by `drive_o` together with `rdata_o`, and `rdata_o` reads as zero whenever the drive flag is low.

Top module: `latched_sram`

## Requirements
- R1: The array holds 2048 bytes selected by an 11-bit address. Every location from 0 to 2047 returns the byte last written to it.
- R2: The address is captured at the clock edge where chip enable is first sampled low after being sampled high. Address pin changes after that edge have no effect until the next falling chip enable, and the data driven during one read stays constant.
- R3: If chip enable is sampled high at an edge, `drive_o` is 0 and `rdata_o` is 0 after that edge.
- R4: If output enable is sampled high at an edge, `drive_o` is 0 and `rdata_o` is 0 after that edge, whatever the other strobes are.
- R5: If write enable is sampled low at an edge, `drive_o` is 0 after that edge, even when output enable is low.
- R6: If chip enable and output enable are sampled low and write enable high at an edge, then after that edge `drive_o` is 1 and `rdata_o` holds the byte at the captured address.
- R7: A write that was open at the previous sample (both enables low) ends at the first sample where write enable or chip enable is high. `wdata_i` at that sample is stored once. A later rise of the other strobe stores nothing more.
- R8: With write enable held low across several chip enable pulses, each pulse writes one location: its captured address gets the data present when chip enable rises.
- R9: After reset the strobes are taken as idle high, and `drive_o` and `rdata_o` are 0.
- R10: If write enable rises while chip enable stays low and output enable is low, the next read output already shows the byte stored at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 11 | Address pins |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when not driving |
| drive_o | output | 1 | Output drive enable for the data bus |

## Verification
Every result appears one clock after the edge that samples its stimulus. The address capture, the write commit and the drive flag each pass through one register stage, and the read data is registered from the array at that same edge. Inputs change on the falling clock edge. For each step the driver queues the outputs expected just after the next rising edge, and the monitor compares them one nanosecond after that edge. Stored data is checked by reading it back in later steps, against a bench-side copy that is updated from the requirements.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned DATA_W = 8;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  output logic ce_fall_o,
  output logic wr_end_o,
  output logic rd_en_o
);
  logic ce_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b1;
      we_q <= 1'b1;
    end else begin
      ce_q <= ce_ni;
      we_q <= we_ni;
    end
  end

  assign ce_fall_o = ce_q & ~ce_ni;
  // write open last sample, first strobe rise closes it
  assign wr_end_o  = ~ce_q & ~we_q & (ce_ni | we_ni);
  assign rd_en_o   = ~ce_ni & ~oe_ni & we_ni;

  // R2
  ce_fall_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_fall_o |=> !ce_fall_o);
endmodule

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int unsigned ADDR_W = sram_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [ADDR_W-1:0] addr_eff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q_o <= '0;
    else if (ce_fall_i) addr_q_o <= addr_i;
  end

  // bypass so a read can start on the capturing edge
  assign addr_eff_o = ce_fall_i ? addr_i : addr_q_o;
endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int unsigned ADDR_W = sram_pkg::ADDR_W,
  parameter int unsigned DATA_W = sram_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && (wr_addr_i == rd_addr_i)) rd_data_o <= wr_data_i;
    else                                     rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/latched_sram.sv
module latched_sram #(
  parameter int unsigned ADDR_W = sram_pkg::ADDR_W,
  parameter int unsigned DATA_W = sram_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              ce_fall, wr_end, rd_en;
  logic [ADDR_W-1:0] addr_q, addr_eff;
  logic [DATA_W-1:0] rd_data;
  logic              drive_q;

  strobe_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .ce_fall_o (ce_fall),
    .wr_end_o  (wr_end),
    .rd_en_o   (rd_en)
  );

  addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_fall_i  (ce_fall),
    .addr_i     (addr_i),
    .addr_q_o   (addr_q),
    .addr_eff_o (addr_eff)
  );

  byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_end),
    .wr_addr_i (addr_q),
    .wr_data_i (wdata_i),
    .rd_addr_i (addr_eff),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= rd_en;
  end

  assign drive_o = drive_q;
  assign rdata_o = drive_q ? rd_data : '0;

  // R3
  ce_off_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (!drive_o && rdata_o == '0));
  // R4
  oe_off_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> (!drive_o && rdata_o == '0));
  // R5
  we_low_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> !drive_o);
  // R2
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && $past(drive_o)) |-> $stable(rdata_o));
endmodule

// File: tb/sim_latched_sram.sv
`timescale 1ns/1ps
module sim_latched_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        drive;

  int n_run = 0, n_fail = 0;
  logic [7:0] ref_mem [2048];

  bit         q_chk [$];
  bit         q_drv [$];
  logic [7:0] q_dat [$];
  string      q_tag [$];

  always #2.5 clk = ~clk;

  latched_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got drive/data %h expected %h", tag, act, exp);
    end
  endtask

  // one input step; expectation refers to outputs after the next rising edge
  task automatic step(input bit ce, input bit we, input bit oe, input logic [10:0] a,
                      input logic [7:0] d, input bit chk, input bit edrv,
                      input logic [7:0] edat, input string tag);
    @(negedge clk);
    ce_n = ce; we_n = we; oe_n = oe; addr = a; wdata = d;
    q_chk.push_back(chk); q_drv.push_back(edrv); q_dat.push_back(edat); q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q_chk.size() > 0) begin
        bit c, ed; logic [7:0] ev; string t;
        c = q_chk.pop_front(); ed = q_drv.pop_front();
        ev = q_dat.pop_front(); t = q_tag.pop_front();
        if (c) check(drive === ed && rdata === ev, t, {drive, rdata}, {ed, ev});
      end
    end
  end

  // write closed by write enable, address pins disturbed mid-cycle
  task automatic wr_we(input logic [10:0] a, input logic [7:0] d);
    step(0, 0, 1, a, 8'h00, 1, 0, 8'h00, "R5");
    step(0, 0, 0, ~a, 8'h11, 1, 0, 8'h00, "R5");   // oe low but we low: no drive
    step(0, 1, 1, ~a, d, 1, 0, 8'h00, "R4");       // commit here
    step(1, 1, 1, ~a, ~d, 1, 0, 8'h00, "R3");      // ce rise: no second write (R7)
    ref_mem[a] = d;
  endtask

  // write closed by chip enable, write enable left low
  task automatic wr_ce(input logic [10:0] a, input logic [7:0] d);
    step(0, 0, 1, a, 8'h00, 1, 0, 8'h00, "R8");
    step(1, 0, 1, ~a, d, 1, 0, 8'h00, "R8");
    ref_mem[a] = d;
  endtask

  task automatic rd(input logic [10:0] a, input string tag);
    step(0, 1, 0, a, 8'h00, 1, 1, ref_mem[a], tag);          // R6
    step(0, 1, 0, a ^ 11'h001, 8'h00, 1, 1, ref_mem[a], "R2");
    step(0, 1, 1, a, 8'h00, 1, 0, 8'h00, "R4");
    step(1, 1, 0, a, 8'h00, 1, 0, 8'h00, "R3");
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(drive === 1'b0 && rdata === 8'h00, "R9", {drive, rdata}, 9'h000);

    // R1: corners and middle, closed by write enable (R7)
    wr_we(11'd0, 8'hA5);
    wr_we(11'd2047, 8'h3C);
    wr_we(11'd1024, 8'h7E);
    rd(11'd0, "R1");
    rd(11'd2047, "R1");
    rd(11'd1024, "R7");

    // R8: write enable held low across four chip enable pulses
    wr_ce(11'd5, 8'h51);
    wr_ce(11'd6, 8'h62);
    wr_ce(11'd7, 8'h73);
    wr_ce(11'd8, 8'h84);
    step(1, 1, 1, 11'd0, 8'h00, 1, 0, 8'h00, "R3");
    rd(11'd5, "R8");
    rd(11'd6, "R8");
    rd(11'd7, "R8");
    rd(11'd8, "R8");

    // R4: output enable high during a read-shaped cycle
    step(0, 1, 1, 11'd5, 8'h00, 1, 0, 8'h00, "R4");
    step(1, 1, 1, 11'd5, 8'h00, 1, 0, 8'h00, "R3");

    // R10: write enable rises with oe low, chip enable stays low
    step(0, 0, 1, 11'd300, 8'h00, 1, 0, 8'h00, "R5");
    step(0, 1, 0, 11'd300, 8'hC9, 1, 1, 8'hC9, "R10");
    step(0, 1, 0, 11'd301, 8'h00, 1, 1, 8'hC9, "R2");
    step(1, 1, 1, 11'd0, 8'h00, 1, 0, 8'h00, "R3");
    ref_mem[11'd300] = 8'hC9;
    rd(11'd300, "R10");

    // overwrite and re-read
    wr_we(11'd0, 8'h5A);
    rd(11'd0, "R1");

    step(1, 1, 1, 11'd0, 8'h00, 0, 0, 8'h00, "idle");
    wait (q_chk.size() == 0);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule